// File: doc/BRIEF.md
# Per-Destination Queued Input Buffer

This block buffers the cells that reach one input port of a cell switch. Each arriving cell carries the index of the output it is bound for. The block files the cell into a queue kept for that output alone. A cell waiting for a busy output therefore never holds back a cell bound for a different output. All the queues share one pool of cell slots. Each queue is a linked list threaded through that pool, so any single queue may grow to fill the whole pool.

A slot is one clock cycle. In each slot at most one cell may arrive and at most one cell may leave. The scheduler sees the occupancy of every queue and a non-empty flag for each, and it uses them as matching weights and eligibility. When the scheduler grants an output, the oldest cell of that output's queue is removed at the clock edge that ends the slot. The cell then appears on a registered valid/data output during the following slot. The number of outputs (a power of two), the pool depth and the cell width are parameters.

Top module: `voq_input_buffer`

## Requirements
- R1: After reset every queue occupancy is zero, every non-empty flag is low, `out_valid` and `grant_err` are low and `drop_cnt` is zero.
- R2: A cell offered with `in_valid` high, while the pool holds fewer than DEPTH cells at the start of the slot, raises the occupancy of queue `in_dest` by one from the next cycle on. It leaves every other queue's occupancy as it was, unless that queue is granted in the same slot.
- R3: A grant (`grant_valid` high) to a queue whose occupancy is above zero at the start of the slot lowers that occupancy by one. In the next cycle it drives `out_valid` high, `out_dest` equal to the granted index, and `out_data` equal to the oldest cell of that queue.
- R4: Cells of one queue leave in the order they arrived, whatever the traffic on the other queues.
- R5: When one queue receives an arrival and a grant in the same slot, its occupancy is unchanged and the departing cell is the oldest cell it held before the slot.
- R6: A grant to a queue whose occupancy is zero at the start of the slot removes nothing and leaves every occupancy unchanged. In the next cycle `out_valid` is low and `grant_err` is high for one cycle.
- R7: A cell offered while the pool already holds DEPTH cells at the start of the slot is discarded, even if a grant frees a slot in the same slot. `drop_cnt` rises by one and saturates at its maximum value.
- R8: Bit j of `nonempty` is high exactly when the occupancy of queue j is above zero.
- R9: The pool is shared: a single queue can hold all DEPTH cells, and slots freed by departures are reused by any queue. The total occupancy never exceeds DEPTH.
- R10: `occ` packs the occupancies with queue j in bits [j*CNT_W +: CNT_W], where CNT_W = clog2(DEPTH+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one slot |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A cell is offered this slot |
| in_dest | input | OW = clog2(NUM_OUT) | Destination output of the offered cell |
| in_data | input | DATA_W | Cell payload |
| grant_valid | input | 1 | Scheduler grants an output this slot |
| grant_idx | input | OW | Granted output index |
| occ | output | NUM_OUT*CNT_W | Packed per-queue occupancy counts |
| nonempty | output | NUM_OUT | Per-queue eligibility flags |
| out_valid | output | 1 | A dequeued cell is presented |
| out_dest | output | OW | Output the presented cell was queued for |
| out_data | output | DATA_W | Payload of the presented cell |
| grant_err | output | 1 | One-cycle flag: the previous grant hit an empty queue |
| drop_cnt | output | DROP_W | Saturating count of cells discarded for lack of space |

## Verification
The hardest situation to reach is a queue holding exactly one cell that receives an arrival and a grant in the same slot. In that slot the head pointer must move to the new cell and not follow a stale link. A close second is an arrival to a full pool in the same slot as a departure. The bench reaches the first case with a sweep over every arrival queue, every granted queue and a preload of zero, one or two cells in the granted queue. It reaches the second case by filling the whole pool, first into a single queue and then across several. A long run of seeded random traffic then mixes fills, drains and errors against a queue model kept in the bench.

// File: rtl/voq_pkg.sv
package voq_pkg;
  // width of an index able to address n items, never below one bit
  function automatic int idx_width(int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // width of a counter able to hold 0..n
  function automatic int cnt_width(int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/voq_slot_pool.sv
module voq_slot_pool #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             give,
  input  logic [PTR_W-1:0] give_idx,
  output logic [PTR_W-1:0] pick_idx,
  output logic             full
);
  logic [DEPTH-1:0] used_q;
  logic [DEPTH-1:0] set_m, clr_m;

  // lowest slot whose busy bit is clear
  function automatic logic [PTR_W-1:0] lowest_free(logic [DEPTH-1:0] busy);
    logic [PTR_W-1:0] r;
    r = '0;
    for (int k = DEPTH - 1; k >= 0; k--)
      if (!busy[k]) r = PTR_W'(k);
    return r;
  endfunction

  assign pick_idx = lowest_free(used_q);
  assign full     = &used_q;
  assign set_m    = take ? (DEPTH'(1) << pick_idx) : '0;
  assign clr_m    = give ? (DEPTH'(1) << give_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= (used_q | set_m) & ~clr_m;
  end
endmodule

// File: rtl/voq_cell_store.sv
module voq_cell_store #(
  parameter int DEPTH  = 8,
  parameter int PTR_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lnk_en,
  input  logic [PTR_W-1:0]  lnk_addr,
  input  logic [PTR_W-1:0]  lnk_ptr,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  rd_next
);
  logic [DATA_W-1:0] cell_q [DEPTH];
  logic [PTR_W-1:0]  next_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)  cell_q[wr_addr] <= wr_data;
    if (lnk_en) next_q[lnk_addr] <= lnk_ptr;
  end

  assign rd_data = cell_q[rd_addr];
  assign rd_next = next_q[rd_addr];
endmodule

// File: rtl/voq_queue_ctrl.sv
module voq_queue_ctrl #(
  parameter int PTR_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq,
  input  logic             deq,
  input  logic [PTR_W-1:0] new_slot,
  input  logic [PTR_W-1:0] deq_next,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             link_en
);
  logic empty_after;

  function automatic logic [CNT_W-1:0] occ_step(logic [CNT_W-1:0] c, logic e, logic d);
    return c + CNT_W'(e) - CNT_W'(d);
  endfunction

  // queue holds nothing once this slot's departure is taken out
  assign empty_after = (count == '0) || (deq && count == CNT_W'(1));
  assign link_en     = enq && !empty_after;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (enq && empty_after) head <= new_slot;
      else if (deq)           head <= deq_next;
      if (enq) tail <= new_slot;
      count <= occ_step(count, enq, deq);
    end
  end
endmodule

// File: rtl/voq_input_buffer.sv
module voq_input_buffer #(
  parameter int NUM_OUT = 4,
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 8,
  parameter int DROP_W  = 8,
  localparam int OW     = voq_pkg::idx_width(NUM_OUT),
  localparam int PTR_W  = voq_pkg::idx_width(DEPTH),
  localparam int CNT_W  = voq_pkg::cnt_width(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [OW-1:0]            in_dest,
  input  logic [DATA_W-1:0]        in_data,
  input  logic                     grant_valid,
  input  logic [OW-1:0]            grant_idx,
  output logic [NUM_OUT*CNT_W-1:0] occ,
  output logic [NUM_OUT-1:0]       nonempty,
  output logic                     out_valid,
  output logic [OW-1:0]            out_dest,
  output logic [DATA_W-1:0]        out_data,
  output logic                     grant_err,
  output logic [DROP_W-1:0]        drop_cnt
);
  logic [PTR_W-1:0]  q_head [NUM_OUT];
  logic [PTR_W-1:0]  q_tail [NUM_OUT];
  logic [CNT_W-1:0]  q_cnt  [NUM_OUT];
  logic [NUM_OUT-1:0] q_link;

  logic              pool_full;
  logic [PTR_W-1:0]  pick_idx;
  logic [PTR_W-1:0]  rd_addr, rd_next;
  logic [DATA_W-1:0] rd_data;

  // named slot events
  logic enq_fire, drop_fire, deq_fire, gerr_fire;

  assign enq_fire  = in_valid && !pool_full;
  assign drop_fire = in_valid && pool_full;
  assign deq_fire  = grant_valid && nonempty[grant_idx];
  assign gerr_fire = grant_valid && !nonempty[grant_idx];
  assign rd_addr   = q_head[grant_idx];

  voq_slot_pool #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .take(enq_fire), .give(deq_fire), .give_idx(rd_addr),
    .pick_idx(pick_idx), .full(pool_full)
  );

  voq_cell_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk),
    .wr_en(enq_fire), .wr_addr(pick_idx), .wr_data(in_data),
    .lnk_en(q_link[in_dest]), .lnk_addr(q_tail[in_dest]), .lnk_ptr(pick_idx),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_next(rd_next)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_q
    voq_queue_ctrl #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .enq(enq_fire && in_dest == OW'(g)),
      .deq(deq_fire && grant_idx == OW'(g)),
      .new_slot(pick_idx), .deq_next(rd_next),
      .head(q_head[g]), .tail(q_tail[g]), .count(q_cnt[g]),
      .link_en(q_link[g])
    );
    assign occ[g*CNT_W +: CNT_W] = q_cnt[g];
    assign nonempty[g]           = q_cnt[g] != '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dest  <= '0;
      out_data  <= '0;
      grant_err <= 1'b0;
      drop_cnt  <= '0;
    end else begin
      out_valid <= deq_fire;
      grant_err <= gerr_fire;
      if (deq_fire) begin
        out_dest <= grant_idx;
        out_data <= rd_data;
      end
      if (drop_fire && drop_cnt != '1) drop_cnt <= drop_cnt + DROP_W'(1);
    end
  end
endmodule

// File: rtl/voq_input_buffer_chk.sv
module voq_input_buffer_chk #(
  parameter int NUM_OUT = 4,
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 8,
  parameter int DROP_W  = 8,
  localparam int OW     = voq_pkg::idx_width(NUM_OUT),
  localparam int CNT_W  = voq_pkg::cnt_width(DEPTH),
  localparam int TOT_W  = CNT_W + OW + 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [OW-1:0]            in_dest,
  input logic                     grant_valid,
  input logic [OW-1:0]            grant_idx,
  input logic [NUM_OUT*CNT_W-1:0] occ,
  input logic [NUM_OUT-1:0]       nonempty,
  input logic                     out_valid,
  input logic [OW-1:0]            out_dest,
  input logic                     grant_err,
  input logic [DROP_W-1:0]        drop_cnt,
  input logic                     enq_fire,
  input logic                     deq_fire
);
  logic [TOT_W-1:0]   tot;
  logic [NUM_OUT-1:0] ne_exp;

  function automatic logic [CNT_W-1:0] occ_of(logic [NUM_OUT*CNT_W-1:0] v, logic [OW-1:0] i);
    return v[int'(i)*CNT_W +: CNT_W];
  endfunction

  always_comb begin
    tot = '0;
    for (int k = 0; k < NUM_OUT; k++) begin
      tot       = tot + TOT_W'(occ[k*CNT_W +: CNT_W]);
      ne_exp[k] = occ[k*CNT_W +: CNT_W] != '0;
    end
  end

  // R9
  pool_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tot <= TOT_W'(DEPTH));

  // R8
  eligible_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nonempty == ne_exp);

  // R3
  grant_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && occ_of(occ, grant_idx) != '0 |=> out_valid && !grant_err && out_dest == $past(grant_idx));

  // R6
  empty_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && occ_of(occ, grant_idx) == '0 |=> grant_err && !out_valid);

  // R2
  enq_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && tot != TOT_W'(DEPTH) && !grant_valid
    |=> occ_of(occ, $past(in_dest)) == $past(occ_of(occ, in_dest)) + CNT_W'(1));

  // R5
  same_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire && deq_fire && in_dest == grant_idx
    |=> occ_of(occ, $past(in_dest)) == $past(occ_of(occ, in_dest)));

  // R7
  drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && tot == TOT_W'(DEPTH) && drop_cnt != '1
    |=> drop_cnt == $past(drop_cnt) + DROP_W'(1));
endmodule

bind voq_input_buffer voq_input_buffer_chk #(
  .NUM_OUT(NUM_OUT), .DEPTH(DEPTH), .DATA_W(DATA_W), .DROP_W(DROP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
  .grant_valid(grant_valid), .grant_idx(grant_idx), .occ(occ),
  .nonempty(nonempty), .out_valid(out_valid), .out_dest(out_dest),
  .grant_err(grant_err), .drop_cnt(drop_cnt),
  .enq_fire(enq_fire), .deq_fire(deq_fire)
);

// File: tb/tb_voq_input_buffer.sv
`timescale 1ns/1ps
module tb_voq_input_buffer;
  localparam int NO = 4, DP = 8, DW = 8, DRW = 8, OW = 2, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, grant_valid = 1'b0;
  logic [OW-1:0] in_dest = '0, grant_idx = '0;
  logic [DW-1:0] in_data = '0;
  logic [NO*CW-1:0] occ;
  logic [NO-1:0] nonempty;
  logic out_valid, grant_err;
  logic [OW-1:0] out_dest;
  logic [DW-1:0] out_data;
  logic [DRW-1:0] drop_cnt;

  int n_chk = 0, n_bad = 0, drops = 0, total = 0;
  bit done = 1'b0;
  int mq [NO][$];

  always #2.5 clk = ~clk;

  voq_input_buffer #(.NUM_OUT(NO), .DEPTH(DP), .DATA_W(DW), .DROP_W(DRW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .grant_valid(grant_valid), .grant_idx(grant_idx), .occ(occ), .nonempty(nonempty),
    .out_valid(out_valid), .out_dest(out_dest), .out_data(out_data),
    .grant_err(grant_err), .drop_cnt(drop_cnt));

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(string req);
    for (int q = 0; q < NO; q++) begin
      check(occ[q*CW +: CW] == CW'(mq[q].size()), {req, "/R2 R10 occ"}, int'(occ[q*CW +: CW]), mq[q].size());
      check(nonempty[q] == (mq[q].size() > 0), "R8 nonempty", int'(nonempty[q]), int'(mq[q].size() > 0));
    end
    check(drop_cnt == DRW'(drops), "R7 drop_cnt", int'(drop_cnt), drops);
  endtask

  // one slot: drive, update model, check after the edge
  task automatic slot(bit iv, int id, int idat, bit gv, int gi, string req);
    bit exp_err, exp_ov;
    int exp_d;
    @(negedge clk);
    in_valid = iv; in_dest = OW'(id); in_data = DW'(idat);
    grant_valid = gv; grant_idx = OW'(gi);
    exp_err = gv && mq[gi].size() == 0;
    exp_ov  = gv && !exp_err;
    exp_d   = 0;
    if (iv && total >= DP && drops < 255) drops++;
    if (exp_ov) begin exp_d = mq[gi].pop_front(); total--; end
    if (iv && (total + int'(exp_ov)) < DP + int'(exp_ov) && (total + int'(exp_ov)) < DP) begin
      mq[id].push_back(idat); total++;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; grant_valid = 1'b0;
    check(out_valid == exp_ov, {req, "/R3 out_valid"}, int'(out_valid), int'(exp_ov));
    check(grant_err == exp_err, {req, "/R6 grant_err"}, int'(grant_err), int'(exp_err));
    if (exp_ov) begin
      check(out_data == DW'(exp_d), {req, "/R4 out_data"}, int'(out_data), exp_d);
      check(out_dest == OW'(gi), {req, "/R3 out_dest"}, int'(out_dest), gi);
    end
    check_state(req);
  endtask

  task automatic drain();
    for (int q = 0; q < NO; q++)
      while (mq[q].size() > 0) slot(0, 0, 0, 1, q, "R4 drain");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(grant_err == 1'b0, "R1 grant_err", int'(grant_err), 0);
    check_state("R1");

    // R2 R4: two cells per queue, drained interleaved
    for (int i = 0; i < 2; i++)
      for (int q = 0; q < NO; q++) slot(1, q, 16 * q + i + 1, 0, 0, "R2 fill");
    for (int i = 0; i < 2; i++)
      for (int q = NO - 1; q >= 0; q--) slot(0, 0, 0, 1, q, "R4 order");

    // R5 R6 sweep: arrival queue x granted queue x preload 0..2
    for (int pre = 0; pre < 3; pre++)
      for (int gi = 0; gi < NO; gi++)
        for (int id = 0; id < NO; id++) begin
          for (int k = 0; k < pre; k++) slot(1, gi, 100 + k, 0, 0, "R2 preload");
          slot(1, id, 200 + id, 1, gi, (id == gi) ? "R5 same" : (pre == 0 ? "R6 empty" : "R3 cross"));
          drain();
        end

    // R9: one queue takes the whole pool, then R7 drops
    for (int k = 0; k < DP; k++) slot(1, 3, 50 + k, 0, 0, "R9 one queue");
    slot(1, 1, 99, 0, 0, "R7 full drop");
    slot(1, 0, 98, 1, 3, "R7 drop with departure");
    slot(1, 0, 97, 0, 0, "R9 reuse");
    slot(1, 2, 96, 1, 2, "R6 empty while full");
    drain();

    // seeded random traffic
    for (int t = 0; t < 3000; t++)
      slot(($urandom % 4) != 0, $urandom % NO, $urandom % 256,
           ($urandom % 3) == 0, $urandom % NO, "R4 random");
    drain();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule